// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Full Detection

This block is a first-in first-out buffer for a single clock domain. A producer pushes words through a write port that has a write enable and a full flag. A consumer pops words through a read port that has a read enable and an empty flag. Words are held in a small register array. An occupancy output reports how many words are currently held.

A parameter picks one of two ways to decide when the buffer is full. In the spare-slot mode, the pointers are exactly as wide as the storage address. The buffer reports full when advancing the write pointer would make it equal to the read pointer, so one slot is never used. In the wrap-bit mode, each pointer carries one extra bit above the address. Full is then a match of the address bits together with a mismatch of the extra bit, so every slot can be used and no adder is needed. Storage is always addressed with the low address bits only.

Read data is registered: a word popped on one clock edge appears on the read data output after that edge. It stays there until the next accepted read. A synchronous reset empties the buffer.

Top module: `sfifo_top`

## Requirements
- R1: When reset is high at a clock edge, after that edge `empty` is 1, `full` is 0, `count` is 0 and `rd_data` is 0.
- R2: `empty` is 1 exactly when the read and write pointers are equal, that is, when `count` is 0.
- R3: With `MODE = FM_SPARE` and `ADDR_W = 5`, `full` rises when 31 words are held, and `count` never exceeds 31.
- R4: With `MODE = FM_WRAP` and `ADDR_W = 5`, `full` rises only when all 32 slots are held, and `count` reaches 32.
- R5: A write while `full` is 1 is ignored. `count` stays the same and the stored words are unchanged, as later reads show.
- R6: A read while `empty` is 1 is ignored. `count` stays at 0 and `rd_data` keeps its previous value.
- R7: When `wr_en` and `rd_en` are both high and both are allowed by the flags, both are accepted in the same cycle and `count` does not change.
- R8: After an accepted read at a clock edge, `rd_data` shows the oldest held word, and words leave in the order they were written.
- R9: `count` equals the number of words held: write pointer minus read pointer, taken modulo the pointer width. It rises by 1 on a write-only cycle and falls by 1 on a read-only cycle.
- R10: Order and flags stay correct over long traffic that wraps both pointers around the storage many times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| full | output | 1 | No write is accepted while this is high |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| empty | output | 1 | No read is accepted while this is high |
| count | output | ADDR_W+1 | Number of words held |

## Verification
A write and a read can fall in the same cycle. This is the case where the two pointers move together, and where a flag can refuse one of the two requests. The bench provokes it in three places: in the middle of the fill range, with the buffer exactly full, and with the buffer exactly empty. It also raises both enables at random during long runs. A behavioural queue model decides each cycle which request is allowed, from its own size before the edge. It then compares count, both flags and the read word against both the spare-slot instance and the wrap-bit instance.

// File: rtl/fifo_sel_pkg.sv
package fifo_sel_pkg;

    // How the full condition is detected
    typedef enum logic {
        FM_SPARE = 1'b0,  // address-width pointers, one slot kept free
        FM_WRAP  = 1'b1   // pointers carry an extra lap bit, all slots usable
    } full_mode_e;

    function automatic int unsigned ptr_width(input int unsigned addr_w, input full_mode_e mode);
        return (mode == FM_WRAP) ? addr_w + 1 : addr_w;
    endfunction

endpackage

// File: rtl/sfifo_ptr.sv
module sfifo_ptr #(
    parameter int unsigned PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
    parameter int unsigned             ADDR_W = 5,
    parameter fifo_sel_pkg::full_mode_e MODE  = fifo_sel_pkg::FM_WRAP,
    localparam int unsigned            PTR_W  = fifo_sel_pkg::ptr_width(ADDR_W, MODE)
) (
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr,
    output logic             is_full,
    output logic             is_empty
);

    // Both modes: empty when the pointers are identical
    assign is_empty = (wptr == rptr);

    generate
        if (MODE == fifo_sel_pkg::FM_WRAP) begin : g_wrap
            logic same_slot;
            assign same_slot = (wptr[ADDR_W-1:0] == rptr[ADDR_W-1:0]);
            assign is_full   = same_slot && (wptr[ADDR_W] != rptr[ADDR_W]);
        end else begin : g_spare
            logic [PTR_W-1:0] wnext;
            assign wnext   = wptr + 1'b1;
            assign is_full = (wnext == rptr);
        end
    endgenerate

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/sfifo_top.sv
module sfifo_top #(
    parameter int unsigned              DATA_W = 8,
    parameter int unsigned              ADDR_W = 5,
    parameter fifo_sel_pkg::full_mode_e MODE   = fifo_sel_pkg::FM_WRAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic [ADDR_W:0]   count
);

    localparam int unsigned PTR_W = fifo_sel_pkg::ptr_width(ADDR_W, MODE);
    localparam int unsigned CNT_W = ADDR_W + 1;

    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic [PTR_W-1:0] fill;
    logic             push;
    logic             pop;

    // Requests are taken only when the flags allow them
    assign push = wr_en && !full;
    assign pop  = rd_en && !empty;

    sfifo_ptr #(.PTR_W(PTR_W)) u_wptr (
        .clk (clk),
        .rst (rst),
        .adv (push),
        .ptr (wptr)
    );

    sfifo_ptr #(.PTR_W(PTR_W)) u_rptr (
        .clk (clk),
        .rst (rst),
        .adv (pop),
        .ptr (rptr)
    );

    sfifo_flags #(.ADDR_W(ADDR_W), .MODE(MODE)) u_flags (
        .wptr     (wptr),
        .rptr     (rptr),
        .is_full  (full),
        .is_empty (empty)
    );

    // Storage sees only the low address bits of each pointer
    sfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (push),
        .waddr (wptr[ADDR_W-1:0]),
        .wdata (wr_data),
        .re    (pop),
        .raddr (rptr[ADDR_W-1:0]),
        .rdata (rd_data)
    );

    assign fill  = wptr - rptr;
    assign count = CNT_W'(fill);

endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
    parameter int unsigned              DATA_W = 8,
    parameter int unsigned              ADDR_W = 5,
    parameter fifo_sel_pkg::full_mode_e MODE   = fifo_sel_pkg::FM_WRAP
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              full,
    input logic              empty,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W:0]   count
);

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned CAP   = (MODE == fifo_sel_pkg::FM_WRAP) ? DEPTH : DEPTH - 1;

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (empty && !full && count == '0 && rd_data == '0));

    // R2
    a_r2_empty_means_zero: assert property (@(posedge clk) disable iff (rst)
        empty == (count == '0));

    // R3 / R4
    a_r3_r4_full_level: assert property (@(posedge clk) disable iff (rst)
        full == (32'(count) == CAP));

    a_r3_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        32'(count) <= CAP);

    // R5
    a_r5_write_when_full: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (count == $past(count)));

    // R6
    a_r6_read_when_empty: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (count == '0 && $stable(rd_data)));

    // R7
    a_r7_both_accepted: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !full && !empty) |=> (count == $past(count)));

    // R9
    a_r9_step_up: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full && !(rd_en && !empty)) |=> (32'(count) == 32'($past(count)) + 1));

    a_r9_step_down: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty && !(wr_en && !full)) |=> (32'(count) + 1 == 32'($past(count))));

endmodule

bind sfifo_top sfifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE(MODE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .full    (full),
    .empty   (empty),
    .rd_data (rd_data),
    .count   (count)
);

// File: tb/test_sfifo_top.sv
module test_sfifo_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int AW         = 5;
    localparam int CAP_W      = 32;  // wrap-bit instance
    localparam int CAP_S      = 31;  // spare-slot instance
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;

    logic          full_w, empty_w, full_s, empty_s;
    logic [DW-1:0] rdat_w, rdat_s;
    logic [AW:0]   cnt_w, cnt_s;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int   qw[$];
    int   qs[$];
    int   exp_rw = 0;
    int   exp_rs = 0;
    int   next_word = 1;
    int   lcg = 12345;
    string dtag = "R8";

    always #(CLK_PERIOD/2) clk = ~clk;

    sfifo_top #(.DATA_W(DW), .ADDR_W(AW), .MODE(fifo_sel_pkg::FM_WRAP)) i_sfifo_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full_w),
        .rd_en(rd_en), .rd_data(rdat_w), .empty(empty_w), .count(cnt_w)
    );

    sfifo_top #(.DATA_W(DW), .ADDR_W(AW), .MODE(fifo_sel_pkg::FM_SPARE)) i_sfifo_top_spare (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full_s),
        .rd_en(rd_en), .rd_data(rdat_s), .empty(empty_s), .count(cnt_s)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2", "wrap empty", int'(empty_w), int'(qw.size() == 0));
        chk("R2", "spare empty", int'(empty_s), int'(qs.size() == 0));
        chk("R4", "wrap full", int'(full_w), int'(qw.size() == CAP_W));
        chk("R3", "spare full", int'(full_s), int'(qs.size() == CAP_S));
        chk("R9", "wrap count", int'(cnt_w), qw.size());
        chk("R9", "spare count", int'(cnt_s), qs.size());
        chk(dtag, "wrap rd_data", int'(rdat_w), exp_rw);
        chk(dtag, "spare rd_data", int'(rdat_s), exp_rs);
    endtask

    // One clock: drive at the falling edge, update the model, compare at the next falling edge
    task automatic cyc(input bit we, input bit re);
        bit aw_w, ar_w, aw_s, ar_s;
        wr_en   = we;
        rd_en   = re;
        wr_data = DW'(next_word);
        aw_w = we && (qw.size() < CAP_W);
        ar_w = re && (qw.size() > 0);
        aw_s = we && (qs.size() < CAP_S);
        ar_s = re && (qs.size() > 0);
        @(posedge clk);
        @(negedge clk);
        if (ar_w) exp_rw = qw.pop_front();
        if (aw_w) qw.push_back(next_word % 256);
        if (ar_s) exp_rs = qs.pop_front();
        if (aw_s) qs.push_back(next_word % 256);
        if (we) next_word++;
        compare_all();
    endtask

    initial begin : watchdog
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int keep_w;
        int keep_s;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "wrap empty", int'(empty_w), 1);
        chk("R1", "wrap full", int'(full_w), 0);
        chk("R1", "wrap count", int'(cnt_w), 0);
        chk("R1", "wrap rd_data", int'(rdat_w), 0);
        chk("R1", "spare empty", int'(empty_s), 1);
        chk("R1", "spare full", int'(full_s), 0);
        chk("R1", "spare count", int'(cnt_s), 0);
        chk("R1", "spare rd_data", int'(rdat_s), 0);
        rst = 1'b0;

        // R3 / R4 / R5: overfill
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0);
        chk("R4", "wrap count at full", int'(cnt_w), 32);
        chk("R3", "spare count at full", int'(cnt_s), 31);
        chk("R5", "wrap full held", int'(full_w), 1);
        keep_w = int'(cnt_w);
        keep_s = int'(cnt_s);
        cyc(1'b1, 1'b0);
        chk("R5", "wrap count after refused write", int'(cnt_w), keep_w);
        chk("R5", "spare count after refused write", int'(cnt_s), keep_s);

        // R5 / R8: drain and confirm stored words untouched
        dtag = "R5";
        cyc(1'b0, 1'b1);
        chk("R8", "wrap first word", int'(rdat_w), 1);
        chk("R8", "spare first word", int'(rdat_s), 1);
        for (int i = 0; i < 36; i++) cyc(1'b0, 1'b1);

        // R6: reads on empty
        dtag = "R6";
        keep_w = int'(rdat_w);
        keep_s = int'(rdat_s);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1);
        chk("R6", "wrap rd_data held", int'(rdat_w), keep_w);
        chk("R6", "spare rd_data held", int'(rdat_s), keep_s);
        chk("R6", "wrap count still zero", int'(cnt_w), 0);

        // R7: simultaneous traffic mid-range, at empty and at full
        dtag = "R7";
        cyc(1'b1, 1'b1);  // at empty: only the write goes in
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1);
        chk("R7", "wrap count steady", int'(cnt_w), 5);
        chk("R7", "spare count steady", int'(cnt_s), 5);
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b1);  // wrap at full: read only
        chk("R7", "wrap after both at full", int'(cnt_w), 31);
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1);
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1);

        // R10: long random traffic across many pointer laps
        dtag = "R10";
        for (int i = 0; i < 4000; i++) begin
            bit we, re;
            lcg = lcg * 1103515245 + 12345;
            we = ((lcg >>> 16) & 3) != 0;
            re = ((lcg >>> 20) & 3) != 0;
            if (i >= 2000 && i < 2200) re = 1'b0;
            if (i >= 2200 && i < 2400) we = 1'b0;
            cyc(we, re);
        end
        chk("R10", "wrap words written", next_word > 1000 ? 1 : 0, 1);

        // R1: reset mid-traffic
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0);
        wr_en = 1'b0;
        rd_en = 1'b0;
        rst   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        qw.delete();
        qs.delete();
        exp_rw = 0;
        exp_rs = 0;
        chk("R1", "wrap count after reset", int'(cnt_w), 0);
        chk("R1", "spare empty after reset", int'(empty_s), 1);
        dtag = "R8";
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule